// File: doc/BRIEF.md
# Bridge Interrupt Status and Mask Unit

This unit gathers the interrupt-worthy events of a bus bridge and turns them into one level-sensitive interrupt line for the host. Eight local-side event sources arrive as single-cycle pulses. Each pulse sets a sticky bit in a byte-wide local status register. Four bus error sources arrive the same way and set sticky flags in the upper nibble of a half-word bus status register. A byte-wide mask selects which local events may raise the interrupt. A global enable bit in a configuration half-word gates the output as a whole.

The two status registers clear in different ways. Software clears the local status byte in one step by writing zero to it. It clears the bus status flags by writing back the value it read: every flag written as one is cleared. An event that lands in the same cycle as a clearing write always wins, so no event is lost. Software reaches all four registers through a plain register port with write and read strobes. Read data is combinational and has no side effects.

Top module: `bridge_irq_unit`

## Requirements
- R1: After reset every status, mask and enable bit is zero, all four registers read as zero, and `irq_o` is low.
- R2: A pulse on `local_evt[i]` sets bit i of the local status register (address 0, bits 7:0). The bit stays set until cleared, whatever the mask holds. The bit order is 7 mailbox, 6 read abort, 5 write abort, 4 external pin interrupt, 3 parity error, 2 inbound queue post, 1 DMA channel 1 done, 0 DMA channel 0 done.
- R3: A write to address 0 whose low byte is zero clears every local status bit. A write to address 0 with a nonzero low byte changes nothing.
- R4: Pulses on `bus_err_evt[3:0]` set bus status bits 15:12 at address 2. Bit 15 is parity error (`bus_err_evt[3]`), bit 14 system error (`[2]`), bit 13 master abort (`[1]`) and bit 12 target abort (`[0]`). Bits 11:0 read as zero.
- R5: A write to address 2 clears exactly those bus status flags whose data bit in 15:12 is one. Flags whose data bit is zero keep their value.
- R6: When an event pulse and a clearing write to the same status bit fall in one cycle, the bit is set after that edge. This holds for both clearing styles.
- R7: Address 1 holds the mask in bits 7:0, in the same bit order as the local status. It is loaded by a write and read back unchanged, with bits 15:8 reading as zero.
- R8: Address 3 holds the global enable at bit 10. All other bits read as zero. While the enable is zero, `irq_o` is low.
- R9: `irq_o` is high exactly when the enable is set and the bitwise AND of local status and mask is nonzero. It follows from the registers with no further delay, so it changes in the cycle after the edge that updates them.
- R10: `reg_rdata` shows the register selected by `reg_addr` while `reg_rd` is high and is zero while `reg_rd` is low. Reading never changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 local status, 1 mask, 2 bus status, 3 configuration |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational |
| local_evt | input | 8 | Local event pulses, one bit per source |
| bus_err_evt | input | 4 | Bus error pulses: 3 parity, 2 system, 1 master abort, 0 target abort |
| irq_o | output | 1 | Level-sensitive interrupt toward the host |

## Verification
The embedded properties assume that `reg_addr` and `reg_wdata` hold known values whenever `reg_wr` is high and that the event inputs are never unknown after reset. They do not depend on events being isolated pulses. The stimulus drives every input to a defined value from time zero, changes inputs only just after a rising edge, and in its mixed phase lets events repeat on back-to-back cycles and coincide with clearing writes. That covers the event-wins and partial-clear cases without leaving those assumptions.

// File: rtl/bridge_irq_pkg.sv
package bridge_irq_pkg;

  typedef enum logic [1:0] {
    SEL_LSTAT = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_BSTAT = 2'd2,
    SEL_CFG   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic lstat_clr;
    logic mask_ld;
    logic bstat_wr;
    logic cfg_ld;
  } wr_dec_t;

endpackage

// File: rtl/birq_sticky_bulk.sv
module birq_sticky_bulk #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (clr_i ? '0 : stat_q) | evt_i;
  end

  assign stat_o = stat_q;

  // R2: a bit only falls on a bulk clear
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~{W{$past(clr_i)}} & ~stat_q) == '0))
    else $error("local status bit dropped without clear");

  // R3: after a clear only same-cycle events remain
  a_r3_bulk_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((stat_q & ~$past(evt_i)) == '0))
    else $error("bulk clear left stale bits");

  // R6: event beats clear
  a_r6_evt_wins_bulk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)))
    else $error("local event lost");

endmodule

// File: rtl/birq_sticky_w1c.sv
module birq_sticky_w1c #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] stat_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q[b] <= 1'b0;
      else if (evt_i[b]) stat_q[b] <= 1'b1;
      else if (clr_i[b]) stat_q[b] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  // R4: a flag rises only from its own error pulse
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0))
    else $error("bus flag set without event");

  // R5: only flags written as one may fall
  a_r5_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_i) & ~stat_q) == '0))
    else $error("bus flag cleared without a one written");

  // R6: event beats write-one-to-clear
  a_r6_evt_wins_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)))
    else $error("bus error event lost");

endmodule

// File: rtl/birq_ctl_reg.sv
module birq_ctl_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

endmodule

// File: rtl/birq_out_gate.sv
module birq_out_gate #(
  parameter int W = 8
) (
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic         irq_o
);

  logic [W-1:0] live;

  always_comb begin
    live  = stat_i & mask_i;
    irq_o = en_i & (|live);
  end

endmodule

// File: rtl/bridge_irq_unit.sv
module bridge_irq_unit #(
  parameter int DATA_W  = 16,
  parameter int LOC_W   = 8,
  parameter int ERR_W   = 4,
  parameter int ERR_LSB = 12,
  parameter int EN_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LOC_W-1:0]  local_evt,
  input  logic [ERR_W-1:0]  bus_err_evt,
  output logic              irq_o
);
  import bridge_irq_pkg::*;

  localparam int ERR_MSB = ERR_LSB + ERR_W - 1;

  wr_dec_t          dec;
  reg_sel_e         sel;
  logic [LOC_W-1:0] lstat;
  logic [LOC_W-1:0] mask_q;
  logic [ERR_W-1:0] bstat;
  logic [ERR_W-1:0] bclr;
  logic             en_q;

  always_comb begin
    sel           = reg_sel_e'(reg_addr);
    dec           = '0;
    dec.lstat_clr = reg_wr && (sel == SEL_LSTAT) && (reg_wdata[LOC_W-1:0] == '0);
    dec.mask_ld   = reg_wr && (sel == SEL_MASK);
    dec.bstat_wr  = reg_wr && (sel == SEL_BSTAT);
    dec.cfg_ld    = reg_wr && (sel == SEL_CFG);
    bclr          = dec.bstat_wr ? reg_wdata[ERR_MSB:ERR_LSB] : '0;
  end

  birq_sticky_bulk #(.W(LOC_W)) u_lstat (
    .clk(clk), .rst_n(rst_n), .evt_i(local_evt), .clr_i(dec.lstat_clr), .stat_o(lstat)
  );

  birq_sticky_w1c #(.W(ERR_W)) u_bstat (
    .clk(clk), .rst_n(rst_n), .evt_i(bus_err_evt), .clr_i(bclr), .stat_o(bstat)
  );

  birq_ctl_reg #(.W(LOC_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .ld_i(dec.mask_ld), .d_i(reg_wdata[LOC_W-1:0]), .q_o(mask_q)
  );

  birq_ctl_reg #(.W(1)) u_en (
    .clk(clk), .rst_n(rst_n), .ld_i(dec.cfg_ld), .d_i(reg_wdata[EN_BIT]), .q_o(en_q)
  );

  birq_out_gate #(.W(LOC_W)) u_gate (
    .stat_i(lstat), .mask_i(mask_q), .en_i(en_q), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (sel)
        SEL_LSTAT: reg_rdata[LOC_W-1:0]       = lstat;
        SEL_MASK:  reg_rdata[LOC_W-1:0]       = mask_q;
        SEL_BSTAT: reg_rdata[ERR_MSB:ERR_LSB] = bstat;
        SEL_CFG:   reg_rdata[EN_BIT]          = en_q;
        default:   reg_rdata                  = '0;
      endcase
    end
  end

  // R8: output silent while globally disabled
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq_o)
    else $error("irq high while disabled");

  // R9: output needs a pending unmasked event
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((lstat & mask_q) != '0))
    else $error("irq high with nothing pending");

  // R7: mask holds when not written
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.mask_ld |=> $stable(mask_q))
    else $error("mask changed without write");

endmodule

// File: tb/bridge_irq_unit_bench.sv
`timescale 1ns/1ps
module bridge_irq_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [7:0]  local_evt = 8'h0;
  logic [3:0]  bus_err_evt = 4'h0;
  logic        irq_o;

  always #2.5 clk = ~clk;

  bridge_irq_unit u_bridge_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .local_evt(local_evt), .bus_err_evt(bus_err_evt), .irq_o(irq_o)
  );

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    done = 0;

  // behavioural reference state
  logic [7:0] m_ls, m_mask;
  logic [3:0] m_bs;
  logic       m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ls = 8'h0; m_mask = 8'h0; m_bs = 4'h0; m_en = 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          2'd0: if (reg_wdata[7:0] == 8'h0) m_ls = 8'h0;
          2'd1: m_mask = reg_wdata[7:0];
          2'd2: m_bs = m_bs & ~reg_wdata[15:12];
          default: m_en = reg_wdata[10];
        endcase
      end
      m_ls = m_ls | local_evt;
      m_bs = m_bs | bus_err_evt;
    end
  end

  function automatic logic [15:0] m_read(input logic rd, input logic [1:0] a);
    if (!rd) return 16'h0;
    case (a)
      2'd0: return {8'h0, m_ls};
      2'd1: return {8'h0, m_mask};
      2'd2: return {m_bs, 12'h0};
      default: return {5'h0, m_en, 10'h0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compared on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({phase, " irq_o"}, {15'h0, irq_o}, {15'h0, (m_en && ((m_ls & m_mask) != 8'h0))});
      check({phase, " rdata"}, reg_rdata, m_read(reg_rd, reg_addr));
    end
  end

  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [15:0] d, input logic [7:0] le, input logic [3:0] be);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    local_evt = le; bus_err_evt = be;
    @(posedge clk); #1;
  endtask

  task automatic idle_rd(input logic [1:0] a);
    cyc(1'b0, 1'b1, a, 16'h0, 8'h0, 4'h0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    phase = "R1";
    for (int a = 0; a < 4; a++) idle_rd(2'(a));
    check("R1 irq after reset", {15'h0, irq_o}, 16'h0);

    // R2: each local source sets its own bit, mask zero
    phase = "R2";
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b1, 2'd0, 16'h0, 8'(1 << i), 4'h0);
      idle_rd(2'd0);
    end
    check("R2 all sources latched", reg_rdata, 16'h00FF);

    // R3: nonzero write ignored, zero write clears
    phase = "R3";
    cyc(1'b1, 1'b1, 2'd0, 16'h005A, 8'h0, 4'h0);
    idle_rd(2'd0);
    check("R3 nonzero write ignored", reg_rdata, 16'h00FF);
    cyc(1'b1, 1'b1, 2'd0, 16'hFF00, 8'h0, 4'h0);
    idle_rd(2'd0);
    check("R3 zero low byte clears", reg_rdata, 16'h0000);

    // R4: bus error mapping
    phase = "R4";
    cyc(1'b0, 1'b1, 2'd2, 16'h0, 8'h0, 4'b0001);
    idle_rd(2'd2);
    check("R4 target abort bit 12", reg_rdata, 16'h1000);
    cyc(1'b0, 1'b1, 2'd2, 16'h0, 8'h0, 4'b1000);
    idle_rd(2'd2);
    check("R4 parity bit 15", reg_rdata, 16'h9000);
    cyc(1'b0, 1'b1, 2'd2, 16'h0, 8'h0, 4'b0110);
    idle_rd(2'd2);

    // R5: partial write-one-to-clear
    phase = "R5";
    cyc(1'b1, 1'b1, 2'd2, 16'h5FFF, 8'h0, 4'h0);
    idle_rd(2'd2);
    check("R5 clears only ones", reg_rdata, 16'hA000);
    cyc(1'b1, 1'b1, 2'd2, 16'hA000, 8'h0, 4'h0);
    idle_rd(2'd2);
    check("R5 write back clears rest", reg_rdata, 16'h0000);

    // R6: event wins over clears
    phase = "R6";
    cyc(1'b0, 1'b0, 2'd0, 16'h0, 8'h81, 4'h0);
    cyc(1'b1, 1'b1, 2'd0, 16'h0000, 8'h01, 4'h0);
    idle_rd(2'd0);
    check("R6 bulk clear vs event", reg_rdata, 16'h0001);
    cyc(1'b0, 1'b0, 2'd0, 16'h0, 8'h0, 4'b0011);
    cyc(1'b1, 1'b1, 2'd2, 16'h3000, 8'h0, 4'b0010);
    idle_rd(2'd2);
    check("R6 w1c vs event", reg_rdata, 16'h2000);

    // R7: mask readback
    phase = "R7";
    cyc(1'b1, 1'b0, 2'd1, 16'hC3A5, 8'h0, 4'h0);
    idle_rd(2'd1);
    check("R7 mask readback", reg_rdata, 16'h00A5);

    // R8: enable bit and gating
    phase = "R8";
    cyc(1'b0, 1'b0, 2'd0, 16'h0, 8'h04, 4'h0);
    idle_rd(2'd3);
    check("R8 disabled irq low", {15'h0, irq_o}, 16'h0);
    cyc(1'b1, 1'b0, 2'd3, 16'hFFFF, 8'h0, 4'h0);
    idle_rd(2'd3);
    check("R8 only bit 10 reads", reg_rdata, 16'h0400);

    // R9: masking and output
    phase = "R9";
    check("R9 irq with pending masked-in", {15'h0, irq_o}, 16'h1);
    cyc(1'b1, 1'b0, 2'd1, 16'h0002, 8'h0, 4'h0);
    check("R9 irq drops on remask", {15'h0, irq_o}, 16'h0);
    cyc(1'b0, 1'b0, 2'd0, 16'h0, 8'h02, 4'h0);
    check("R9 irq on new event", {15'h0, irq_o}, 16'h1);
    cyc(1'b1, 1'b0, 2'd3, 16'h0000, 8'h0, 4'h0);
    check("R9 irq off with enable", {15'h0, irq_o}, 16'h0);

    // R10: no read strobe, no data, no side effect
    phase = "R10";
    cyc(1'b0, 1'b0, 2'd0, 16'h0, 8'h0, 4'h0);
    check("R10 rdata idle zero", reg_rdata, 16'h0);
    idle_rd(2'd0);
    check("R10 read keeps status", reg_rdata, 16'h0007);

    // mixed traffic
    phase = "R2..mixed R6";
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      logic [7:0] le;
      logic [3:0] be;
      logic       w;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      le = (lfsr[2:0] == 3'd0) ? lfsr[15:8] : 8'h0;
      be = (lfsr[5:3] == 3'd1) ? lfsr[11:8] : 4'h0;
      w  = (lfsr[7:6] == 2'd0);
      cyc(w, lfsr[9], lfsr[13:12],
          (lfsr[14] ? 16'h0000 : {lfsr[7:0], lfsr[15:8]}), le, be);
    end
    cyc(1'b0, 1'b0, 2'd0, 16'h0, 8'h0, 4'h0);
    @(negedge clk);
    finish_run();
  end

endmodule